// File: doc/BRIEF.md
# Three-Axis Sample Output Formatter

This block sits between three per-axis acceleration result streams and a register read port. It keeps the most recent signed 12-bit result of each axis and serves it as two byte registers per axis. Each 16-bit word is either sign-extended to the right or shifted to the top of the word. The order of the two bytes within an axis pair can be swapped. A status byte reports, for each axis, whether an unread sample is waiting and whether an unread sample was overwritten. A freeze option keeps an axis pair from changing between the reads of its two bytes, so the host never pairs a low byte from one sample with a high byte from the next.

Samples arrive together on one valid strobe. Each axis has its own enable. A host read is one cycle with `rd_stb` high and a byte address. The byte appears on `rd_data` one cycle later and stays there until the next read.

Top module: `axis_out_fmt`

## Requirements
- R1: After reset, `rd_data` is 0, `data_rdy` is 0, the status byte reads 0x00, and every axis byte reads 0x00.
- R2: A sample accepted at a clock edge where `smp_valid` is 1 and the axis is enabled can be read by a read issued in the next cycle. With freezing off, a sample arriving between the two byte reads of a pair shows up in the second read.
- R3: With `cfg_left_just`=0, the 16-bit word is the 12-bit sample sign-extended, so bits 15..12 all equal sample bit 11.
- R4: With `cfg_left_just`=1, the 16-bit word is the sample in bits 15..4 with bits 3..0 zero.
- R5: With `cfg_big_end`=0, the lower address of an axis pair returns word bits 7..0 and the higher address returns bits 15..8. With `cfg_big_end`=1, the two are swapped.
- R6: The axis pairs sit at consecutive byte addresses 0x28/0x29 (X), 0x2A/0x2B (Y) and 0x2C/0x2D (Z). Any address other than these and 0x27 reads 0x00.
- R7: Address 0x27 returns the status byte. From bit 7 down it holds: any-axis overrun, Z overrun, Y overrun, X overrun, all-axes available, Z available, Y available, X available.
- R8: An axis's available bit sets when it accepts a sample. It clears when its byte carrying word bits 15..8 is read. `data_rdy` is 1 exactly while all three available bits are 1.
- R9: An axis's overrun bit sets when it accepts a sample while its available bit is still set. It clears together with the available bit.
- R10: While an axis's enable is 0, samples change neither its bytes nor its status bits.
- R11: With `cfg_hold_upd`=1, once either byte of an axis pair is read, that pair keeps its value until the other byte is read. From the next cycle it shows the newest sample the axis accepted.
- R12: `rd_data` changes only at the clock edge after a cycle with `rd_stb`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample set present on the sample inputs |
| smp_x | input | 12 | X axis signed sample |
| smp_y | input | 12 | Y axis signed sample |
| smp_z | input | 12 | Z axis signed sample |
| cfg_axis_en | input | 3 | Per-axis enable, bit 0 X, bit 1 Y, bit 2 Z |
| cfg_left_just | input | 1 | 1: left-justified 16-bit word, 0: right-justified sign-extended |
| cfg_big_end | input | 1 | 1: high byte at the lower address of a pair |
| cfg_hold_upd | input | 1 | 1: freeze a pair between its two byte reads |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 7 | Byte address of the read |
| rd_data | output | 8 | Registered read data |
| data_rdy | output | 1 | All three axes hold unread samples |

## Verification
The formatting path is swept with a stepped set of 12-bit values plus the sign boundaries 0x7FF, 0x800, 0xFFF and 0x001, under all four combinations of justification and byte order. The three axes carry different values so that a crossed axis index shows up. Each pair is read at both addresses, which separates sign extension from zero fill and swapped from unswapped bytes. A sample pushed between the two byte reads tells a frozen pair apart from a continuously updated one. Double pushes, high-byte reads and a disabled middle axis drive the status byte through known values that expose wrong bit positions, wrong clearing and a missing enable gate.

// File: rtl/axfmt_pkg.sv
package axfmt_pkg;

  localparam int AX_N   = 3;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // bit order of the status byte is fixed by the host-side decode
  typedef struct packed {
    logic            any_ovr;
    logic [AX_N-1:0] ovr;
    logic            all_da;
    logic [AX_N-1:0] da;
  } stat_t;

endpackage

// File: rtl/axfmt_lane.sv
module axfmt_lane #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_vld,
  input  logic [W-1:0] smp,
  input  logic         en,
  input  logic         hold,
  input  logic         hit_lo,
  input  logic         hit_hi,
  output logic [W-1:0] val,
  output logic         da,
  output logic         ovr,
  output logic         half
);

  logic [W-1:0] shd_q, val_q;
  logic         half_q, first_lo_q, da_q, ovr_q;

  logic take, hit, done, block, da_eff, ovr_eff;

  always_comb begin
    take    = take_vld & en;
    hit     = hit_lo | hit_hi;
    done    = half_q & (first_lo_q ? hit_hi : hit_lo);
    block   = hold & ((half_q & ~done) | (~half_q & hit));
    da_eff  = da_q & ~hit_hi;
    ovr_eff = ovr_q & ~hit_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q      <= '0;
      val_q      <= '0;
      half_q     <= 1'b0;
      first_lo_q <= 1'b0;
      da_q       <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (take) shd_q <= smp;
      if (!block) val_q <= take ? smp : shd_q;

      if (!hold) begin
        half_q <= 1'b0;
      end else if (hit) begin
        if (!half_q) begin
          half_q     <= 1'b1;
          first_lo_q <= hit_lo;
        end else if (done) begin
          half_q <= 1'b0;
        end
      end

      if (take) begin
        da_q  <= 1'b1;
        ovr_q <= ovr_eff | da_eff;
      end else begin
        da_q  <= da_eff;
        ovr_q <= ovr_eff;
      end
    end
  end

  assign val  = val_q;
  assign da   = da_q;
  assign ovr  = ovr_q;
  assign half = half_q;

endmodule

// File: rtl/axfmt_rdmux.sv
module axfmt_rdmux
  import axfmt_pkg::*;
#(
  parameter int W         = 12,
  parameter int ADDR_W    = 7,
  parameter int BASE_ADDR = 'h28,
  parameter int STAT_ADDR = 'h27
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                left_just,
  input  logic                big_end,
  input  logic [AX_N*W-1:0]   vals,
  input  stat_t               stat,
  output logic [BYTE_W-1:0]   rd_data
);

  localparam int PAD_W  = WORD_W - W;
  localparam int SPAN   = 2 * AX_N;
  localparam int AIDX_W = $clog2(AX_N);

  logic [ADDR_W-1:0] off;
  logic              in_rng, take_hi;
  logic [AIDX_W-1:0] ax;
  logic [W-1:0]      v;
  logic [WORD_W-1:0] word;
  logic [BYTE_W-1:0] byte_nx;

  always_comb begin
    off     = rd_addr - ADDR_W'(BASE_ADDR);
    in_rng  = (rd_addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(SPAN));
    ax      = AIDX_W'(off >> 1);
    v       = '0;
    for (int k = 0; k < AX_N; k++)
      if (ax == AIDX_W'(k)) v = vals[k*W +: W];
    word    = left_just ? {v, {PAD_W{1'b0}}} : {{PAD_W{v[W-1]}}, v};
    take_hi = off[0] ^ big_end;
    if (rd_addr == ADDR_W'(STAT_ADDR))
      byte_nx = stat;
    else if (in_rng)
      byte_nx = take_hi ? word[WORD_W-1 -: BYTE_W] : word[BYTE_W-1:0];
    else
      byte_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= byte_nx;
  end

endmodule

// File: rtl/axis_out_fmt.sv
module axis_out_fmt
  import axfmt_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ADDR_W    = 7,
  parameter int BASE_ADDR = 'h28,
  parameter int STAT_ADDR = 'h27
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_x,
  input  logic [SAMPLE_W-1:0] smp_y,
  input  logic [SAMPLE_W-1:0] smp_z,
  input  logic [2:0]          cfg_axis_en,
  input  logic                cfg_left_just,
  input  logic                cfg_big_end,
  input  logic                cfg_hold_upd,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_data,
  output logic                data_rdy
);

  logic [AX_N*SAMPLE_W-1:0] smp_all;
  logic [AX_N*SAMPLE_W-1:0] lane_val;
  logic [AX_N-1:0]          lane_da, lane_ovr, lane_half;
  stat_t                    stat;

  assign smp_all = {smp_z, smp_y, smp_x};

  for (genvar k = 0; k < AX_N; k++) begin : g_lane
    localparam int EVEN_A = BASE_ADDR + 2 * k;
    logic hit_even, hit_odd;
    assign hit_even = rd_stb && (rd_addr == ADDR_W'(EVEN_A));
    assign hit_odd  = rd_stb && (rd_addr == ADDR_W'(EVEN_A + 1));

    axfmt_lane #(.W(SAMPLE_W)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .take_vld (smp_valid),
      .smp      (smp_all[k*SAMPLE_W +: SAMPLE_W]),
      .en       (cfg_axis_en[k]),
      .hold     (cfg_hold_upd),
      .hit_lo   (cfg_big_end ? hit_odd : hit_even),
      .hit_hi   (cfg_big_end ? hit_even : hit_odd),
      .val      (lane_val[k*SAMPLE_W +: SAMPLE_W]),
      .da       (lane_da[k]),
      .ovr      (lane_ovr[k]),
      .half     (lane_half[k])
    );
  end

  always_comb begin
    stat.any_ovr = |lane_ovr;
    stat.ovr     = lane_ovr;
    stat.all_da  = &lane_da;
    stat.da      = lane_da;
  end

  assign data_rdy = &lane_da;

  axfmt_rdmux #(
    .W         (SAMPLE_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) rdmux_i (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .left_just (cfg_left_just),
    .big_end   (cfg_big_end),
    .vals      (lane_val),
    .stat      (stat),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/axfmt_chk.sv
module axfmt_chk #(
  parameter int W = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           smp_valid,
  input logic [2:0]     cfg_axis_en,
  input logic           cfg_hold_upd,
  input logic           rd_stb,
  input logic [7:0]     rd_data,
  input logic [2:0]     lane_da,
  input logic [2:0]     lane_ovr,
  input logic [2:0]     lane_half,
  input logic [3*W-1:0] lane_val
);

  AST_DA_SET: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ((lane_da & $past(cfg_axis_en)) == $past(cfg_axis_en))); // R8

  AST_DA_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    ((lane_da & ~$past(lane_da) & ~($past(cfg_axis_en) & {3{$past(smp_valid)}})) == 3'b000)); // R10

  AST_OVR_WITH_DA: assert property (@(posedge clk) disable iff (rst)
    ((lane_ovr & ~lane_da) == 3'b000)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_stb) |-> $stable(rd_data)); // R12

  for (genvar k = 0; k < 3; k++) begin : g_frz
    AST_PAIR_FROZEN: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg_hold_upd) && $past(lane_half[k]) && !$past(rd_stb))
        |-> $stable(lane_val[k*W +: W])); // R11
  end

endmodule

bind axis_out_fmt axfmt_chk #(.W(SAMPLE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .smp_valid    (smp_valid),
  .cfg_axis_en  (cfg_axis_en),
  .cfg_hold_upd (cfg_hold_upd),
  .rd_stb       (rd_stb),
  .rd_data      (rd_data),
  .lane_da      (lane_da),
  .lane_ovr     (lane_ovr),
  .lane_half    (lane_half),
  .lane_val     (lane_val)
);

// File: tb/axis_out_fmt_tb_top.sv
`timescale 1ns/1ps
module axis_out_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [2:0]  cfg_axis_en = 3'b111;
  logic        cfg_left_just = 1'b0, cfg_big_end = 1'b0, cfg_hold_upd = 1'b0;
  logic        rd_stb = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        data_rdy;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  axis_out_fmt dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .cfg_axis_en(cfg_axis_en), .cfg_left_just(cfg_left_just),
    .cfg_big_end(cfg_big_end), .cfg_hold_upd(cfg_hold_upd),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .data_rdy(data_rdy)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic push(input int x, input int y, input int z);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_x = 12'(x); smp_y = 12'(y); smp_z = 12'(z);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = 7'(a);
    @(negedge clk);
    rd_stb = 1'b0;
    d = int'(rd_data);
  endtask

  // 16-bit word computed arithmetically from the 12-bit sample
  function automatic int word_of(input int v, input bit left);
    int s;
    if (left) return (v * 16) & 16'hFFFF;
    s = (v >= 2048) ? v - 4096 : v;
    return s & 16'hFFFF;
  endfunction

  // byte at lower (odd=0) or higher (odd=1) address of a pair
  function automatic int byte_at(input int v, input bit left, input bit big, input bit odd);
    int w;
    w = word_of(v, left);
    if (odd ^ big) return (w / 256) & 8'hFF;
    return w & 8'hFF;
  endfunction

  task automatic sweep_one(input int v);
    int vals[3];
    int d;
    vals[0] = v; vals[1] = (v ^ 12'hA5A) & 12'hFFF; vals[2] = (~v) & 12'hFFF;
    push(vals[0], vals[1], vals[2]);
    for (int a = 0; a < 3; a++) begin
      for (int o = 0; o < 2; o++) begin
        rd(8'h28 + 2 * a + o, d);
        // R2 R3 R4 R5 R6: format, order and map
        check(cfg_left_just ? "R4 left-justified" : "R3 sign-extended",
              d, byte_at(vals[a], cfg_left_just, cfg_big_end, o[0]));
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int d;
    do_reset();

    // R1: reset state
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 data_rdy", int'(data_rdy), 0);
    rd(8'h27, d); check("R1 status", d, 0);
    rd(8'h28, d); check("R1 X low", d, 0);
    rd(8'h2D, d); check("R1 Z high", d, 0);

    // R3 R4 R5 sweep over all formats
    for (int m = 0; m < 4; m++) begin
      cfg_left_just = m[0];
      cfg_big_end   = m[1];
      for (int v = 0; v < 4096; v += 39) sweep_one(v);
      sweep_one(12'h7FF); sweep_one(12'h800);
      sweep_one(12'hFFF); sweep_one(12'h001);
    end
    cfg_left_just = 1'b0; cfg_big_end = 1'b0;

    // R6: unmapped addresses
    rd(8'h26, d); check("R6 addr 0x26", d, 0);
    rd(8'h2E, d); check("R6 addr 0x2E", d, 0);
    rd(8'h00, d); check("R6 addr 0x00", d, 0);

    // R7 R8 R9: status bits
    do_reset();
    push(12'h123, 12'h456, 12'h789);
    rd(8'h27, d); check("R7 R8 status after one sample", d, 8'h0F);
    check("R8 data_rdy all set", int'(data_rdy), 1);
    push(12'h124, 12'h457, 12'h78A);
    rd(8'h27, d); check("R9 status after overrun", d, 8'hFF);
    rd(8'h29, d); check("R2 X high newest", d, 8'h01);
    rd(8'h27, d); check("R8 R9 X cleared by high read", d, 8'hE6);
    check("R8 data_rdy cleared", int'(data_rdy), 0);
    rd(8'h2A, d); check("R8 low read keeps Y", d, 8'h57);
    rd(8'h27, d); check("R8 status after low read", d, 8'hE6);

    // R8 with swapped order: lower address is the high byte
    cfg_big_end = 1'b1;
    rd(8'h2A, d); check("R5 R8 Y high at lower addr", d, 8'h04);
    rd(8'h27, d); check("R8 Y cleared big-endian", d, 8'hC4);
    cfg_big_end = 1'b0;

    // R10: disabled Y axis
    do_reset();
    push(12'h111, 12'h222, 12'h333);
    rd(8'h29, d); rd(8'h2B, d); rd(8'h2D, d);
    cfg_axis_en = 3'b101;
    push(12'h444, 12'h555, 12'h666);
    rd(8'h27, d); check("R10 status with Y off", d, 8'h05);
    rd(8'h2A, d); check("R10 Y low unchanged", d, 8'h22);
    rd(8'h2B, d); check("R10 Y high unchanged", d, 8'h02);
    rd(8'h2C, d); check("R10 Z low updated", d, 8'h66);
    cfg_axis_en = 3'b111;

    // R11: freeze between the byte reads
    do_reset();
    cfg_hold_upd = 1'b1;
    push(12'hABC, 12'h0, 12'h0);
    rd(8'h28, d); check("R11 first byte", d, 8'hBC);
    push(12'h345, 12'h0, 12'h0);
    rd(8'h29, d); check("R11 frozen high byte", d, 8'hFA);
    rd(8'h28, d); check("R11 newest after completion", d, 8'h45);
    rd(8'h28, d); check("R11 repeat same byte frozen", d, 8'h45);
    push(12'h9F0, 12'h0, 12'h0);
    rd(8'h28, d); check("R11 still frozen on low", d, 8'h45);
    rd(8'h29, d); check("R11 pair completes old", d, 8'h03);
    rd(8'h29, d); check("R11 released to newest", d, 8'hF9);

    // R2: continuous update between reads
    cfg_hold_upd = 1'b0;
    push(12'hABC, 12'h0, 12'h0);
    rd(8'h28, d); check("R2 low", d, 8'hBC);
    push(12'h345, 12'h0, 12'h0);
    rd(8'h29, d); check("R2 high follows new sample", d, 8'h03);

    // R12: rd_data holds without a strobe
    repeat (3) @(negedge clk);
    check("R12 rd_data held", int'(rd_data), 8'h03);
    push(12'h7FF, 12'h0, 12'h0);
    check("R12 held across sample", int'(rd_data), 8'h03);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule